// File: doc/BRIEF.md
# Two-Register Single-Cycle Accumulator Core

This block is a 16-bit processor core that completes one instruction per clock. It has two working registers: an address/constant register (A) and a data register (D). It also has a 15-bit program counter. Each cycle it reads an instruction word and a data word from outside memories. It drives a data address, a write-data word and a write strobe, and it presents the program counter as the fetch address for the next instruction.

There are two instruction kinds. The first kind loads a 15-bit constant into A. The second kind computes a result from D and a second operand, which is either A or the data word. It can then store that result into any mix of A, D and memory, and it can branch on the sign of the result.

The point the design is built around is the ordering inside a compute instruction. When a compute instruction both writes A and branches, the branch goes to the A value from before that instruction. The value being written to A does not redirect the branch.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high at a rising clock edge, the program counter, A and D are all cleared to 0 by that edge.
- R2: An instruction with bit 15 = 0 loads bits 14..0 into A, zero-extended to 16 bits, and the program counter advances by 1.
- R3: An instruction with bit 15 = 1 is a compute instruction and drives its result on `mem_wdata`. Operand x is always D. Operand y is A when bit 12 = 0 and `mem_rdata` when bit 12 = 1.
- R4: The ALU control bits of a compute instruction are applied in this order: bit 11 clears x, bit 10 inverts x, bit 9 clears y, bit 8 inverts y, bit 7 selects x+y (1) or x AND y (0), and bit 6 inverts the result.
- R5: In a compute instruction, bit 5 stores the result into A and bit 4 stores it into D at the clock edge. Bit 3 raises `mem_we` combinationally in the same cycle. Any combination of the three is legal.
- R6: The branch is taken when at least one of these holds: bit 2 is set and the result is negative; bit 1 is set and the result is zero; bit 0 is set and the result is positive. When the branch is not taken, the program counter advances by 1.
- R7: A taken branch loads the program counter with the A value held at the start of the instruction, even when the same instruction writes A.
- R8: `mem_addr` always shows bits 14..0 of the current A.
- R9: The program "load 3; D=A; A=D-A with branch-if-zero; load 3; 0 with branch-always", started at address 0, produces the program counter sequence 1,2,3,4,3,4 after successive clocks.
- R10: For the program "A=1 with branch-always; 0 with branch-always", the program counter reads 0 after the first clock and 1 after each later clock. A reads 1 after the first clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 16 | Instruction word at the current program counter |
| mem_rdata | input | 16 | Data word read from address `mem_addr` |
| mem_wdata | output | 16 | Compute result, the data to write |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 15 | Data address, the current A |
| pc | output | 15 | Program counter |

## Verification
The hard case is a compute instruction that rewrites A and branches in the same cycle, where the old and new A values differ. In that case a wrong ordering produces a different program counter rather than an obviously broken one. The stimulus reaches this case through short programs held in a bench instruction memory indexed by `pc`. One program branches with A=1, one branches with A=0, and one computes D-A into A with a branch-if-zero, so the old target and the would-be new target are always distinct addresses. A behavioural reference model, which resolves the branch before it applies any register writes, is compared against the ports after every clock. A mixed program also exercises memory reads, memory writes and every ALU control bit.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   instr,
  input  logic [W-1:0]   mem_rdata,
  output logic [W-1:0]   mem_wdata,
  output logic           mem_we,
  output logic [W-2:0]   mem_addr,
  output logic [W-2:0]   pc
);
  localparam int AW = W - 1;

  logic [W-1:0]  a_q, d_q;
  logic [AW-1:0] pc_q;
  logic [W-1:0]  xv, yv, res;
  logic          is_comp, neg, zer, take;

  assign is_comp = instr[W-1];

  always_comb begin
    xv = instr[11] ? '0 : d_q;
    if (instr[10]) xv = ~xv;
    yv = instr[12] ? mem_rdata : a_q;
    if (instr[9]) yv = '0;
    if (instr[8]) yv = ~yv;
    res = instr[7] ? (xv + yv) : (xv & yv);
    if (instr[6]) res = ~res;
  end

  assign neg  = res[W-1];
  assign zer  = (res == '0);
  assign take = is_comp && ((instr[2] && neg) || (instr[1] && zer) ||
                            (instr[0] && !neg && !zer));

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q  <= '0;
      d_q  <= '0;
      pc_q <= '0;
    end else begin
      pc_q <= take ? a_q[AW-1:0] : pc_q + 1'b1;
      if (!is_comp)
        a_q <= {1'b0, instr[AW-1:0]};
      else begin
        if (instr[5]) a_q <= res;
        if (instr[4]) d_q <= res;
      end
    end
  end

  assign mem_wdata = res;
  assign mem_we    = is_comp && instr[3];
  assign mem_addr  = a_q[AW-1:0];
  assign pc        = pc_q;
endmodule

// File: rtl/acc_cpu_checker.sv
module acc_cpu_checker (
  input logic        clk,
  input logic        rst,
  input logic [15:0] instr,
  input logic [15:0] mem_wdata,
  input logic        mem_we,
  input logic [14:0] mem_addr,
  input logic [14:0] pc
);
  AST_RESET_PC: assert property (@(posedge clk) rst |=> pc == 15'd0); // R1
  AST_CONST_LOAD: assert property (@(posedge clk) disable iff (rst)
    !instr[15] |=> mem_addr == $past(instr[14:0])); // R2
  AST_CONST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !instr[15] |-> !mem_we); // R5
  AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (rst)
    (instr[15] && instr[11:6] == 6'b101010) |-> mem_wdata == 16'd0); // R4
  AST_NO_BRANCH_STEP: assert property (@(posedge clk) disable iff (rst)
    (instr[15] && instr[2:0] == 3'b000) |=> pc == $past(pc) + 15'd1); // R6
  AST_BRANCH_OLD_A: assert property (@(posedge clk) disable iff (rst)
    (instr[15] && instr[2:0] == 3'b111) |=> pc == $past(mem_addr)); // R7
endmodule

bind acc_cpu acc_cpu_checker chk (
  .clk(clk), .rst(rst), .instr(instr), .mem_wdata(mem_wdata),
  .mem_we(mem_we), .mem_addr(mem_addr), .pc(pc)
);

// File: tb/acc_cpu_test.sv
`timescale 1ns/1ps
module acc_cpu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr, mem_rdata, mem_wdata;
  logic        mem_we;
  logic [14:0] mem_addr, pc;

  logic [15:0] prog [32];
  logic [15:0] dmem [32];

  int n_cmp = 0, n_bad = 0;
  int expq[$];
  string tagq[$];
  int ma, md, mpc;

  always #2.5 clk = ~clk;

  assign instr     = prog[pc[4:0]];
  assign mem_rdata = dmem[mem_addr[4:0]];
  always @(posedge clk) if (mem_we) dmem[mem_addr[4:0]] <= mem_wdata;

  acc_cpu uut (.clk(clk), .rst(rst), .instr(instr), .mem_rdata(mem_rdata),
               .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_addr(mem_addr), .pc(pc));

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_alu(int ins, int x, int y);
    int r;
    if (ins & (1 << 11)) x = 0;
    if (ins & (1 << 10)) x = ~x;
    if (ins & (1 << 9))  y = 0;
    if (ins & (1 << 8))  y = ~y;
    r = (ins & (1 << 7)) ? x + y : x & y;
    if (ins & (1 << 6)) r = ~r;
    return r & 16'hFFFF;
  endfunction

  task automatic step();
    int ins, res, nxt;
    bit jmp;
    ins = int'(instr);
    res = model_alu(ins, md, (ins & (1 << 12)) ? int'(mem_rdata) : ma);
    check("R1/R6/R7 pc", int'(pc), mpc);
    check("R8 mem_addr", int'(mem_addr), ma & 16'h7FFF);
    if (ins & 16'h8000) begin
      check("R3/R4 mem_wdata (D and operand)", int'(mem_wdata), res);
      check("R5 mem_we", int'(mem_we), (ins >> 3) & 1);
    end else
      check("R5 mem_we on constant", int'(mem_we), 0);
    if (rst) begin
      mpc = 0; ma = 0; md = 0;
    end else if (!(ins & 16'h8000)) begin
      ma = ins & 16'h7FFF;
      mpc = (mpc + 1) & 16'h7FFF;
    end else begin
      jmp = ((ins & 4) && res[15]) || ((ins & 2) && res == 0) ||
            ((ins & 1) && !res[15] && res != 0);
      nxt = jmp ? (ma & 16'h7FFF) : ((mpc + 1) & 16'h7FFF);
      if (ins & (1 << 5)) ma = res;
      if (ins & (1 << 4)) md = res;
      mpc = nxt;
    end
    @(posedge clk);
    @(negedge clk);
    if (expq.size() > 0) check(tagq.pop_front(), int'(pc), expq.pop_front());
  endtask

  task automatic restart();
    rst = 1'b1;
    step();
    check("R1 pc after reset", int'(pc), 0);
    check("R1 A after reset", int'(mem_addr), 0);
    rst = 1'b0;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 32; i++) begin prog[i] = 16'h0000; dmem[i] = 16'(i); end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    ma = 0; md = 0; mpc = 0;
    clear_prog();
    @(negedge clk);

    // R9: old A (3) is the target, not the new A (0)
    prog[0] = 16'h0003; prog[1] = 16'hEC10; prog[2] = 16'hE4E2;
    prog[3] = 16'h0003; prog[4] = 16'hEA87;
    restart();
    foreach (expq[i]) ;
    expq = '{1, 2, 3, 4, 3, 4};
    tagq = '{"R9 pc", "R9 pc", "R9 pc", "R9 pc", "R9 pc", "R9 pc"};
    repeat (6) step();

    // R10: A=1;JMP then 0;JMP
    clear_prog();
    prog[0] = 16'hEFE7; prog[1] = 16'hEA87;
    restart();
    expq = '{0}; tagq = '{"R10 pc"};
    step();
    check("R10 A after first clock", int'(mem_addr), 1);
    expq = '{1, 1, 1}; tagq = '{"R10 pc", "R10 pc", "R10 pc"};
    repeat (3) step();

    // R7: A=0;JMP lands on old A=7, then D;JMP goes to 0
    clear_prog();
    prog[0] = 16'h0007; prog[1] = 16'hEAA7; prog[7] = 16'hE307;
    restart();
    expq = '{1, 7, 0, 1, 7};
    tagq = '{"R2 pc", "R7 pc", "R7 pc", "R7 pc", "R7 pc"};
    repeat (5) step();

    // R2-R6 mixed: memory read/write, ALU variants, conditional branches
    clear_prog();
    prog[0]  = 16'h0005; prog[1]  = 16'hEC10; prog[2]  = 16'h000A;
    prog[3]  = 16'hE308; prog[4]  = 16'hE090; prog[5]  = 16'hF1E8;
    prog[6]  = 16'hE304; prog[7]  = 16'h0003; prog[8]  = 16'hE550;
    prog[9]  = 16'hE010; prog[10] = 16'hE350; prog[11] = 16'h0009;
    prog[12] = 16'hFC10; prog[13] = 16'hE302; prog[14] = 16'h7FFF;
    prog[15] = 16'hE304;
    restart();
    repeat (40) step();

    // R1: reset in the middle of a run
    rst = 1'b1;
    step();
    check("R1 mid-run reset pc", int'(pc), 0);
    rst = 1'b0;
    repeat (4) step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule